// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Check

This block keeps the in-flight loads of an out-of-order core in a circular queue. Loads enter at the tail in program order. They leave from the head once the core reports the youngest committed sequence number. A squash removes every load younger than a given sequence number, and the tail moves back over them. As each load executes, its address is stored. The store queue is outside this block. It is seen only through its tail index, an empty flag and an occupancy count.

When a store executes, it presents the load-queue index it recorded at allocation and its address. The block compares the store against every executed load from that index up to the tail, at a granularity of 256 bytes. The oldest overlapping load is recorded as the ordering violator, and a fault pulse is raised. A violator stays held until the core takes it. While one is held, further store checks are skipped. Loads enter through a valid/ready handshake: `alloc_valid` may stay high for as long as needed, and a load is accepted only on a rising clock edge where `alloc_ready` is also high. Every other pin is plain control or status.

Top module: `ldq_order_ring`

## Requirements
- R1: The queue holds at most LQ_CAP loads, and its ring has LQ_CAP+1 slots. `alloc_ready` is low whenever `lq_count` equals LQ_CAP or `squash_valid` is high. A load is accepted only when `alloc_valid` and `alloc_ready` are both high.
- R2: `alloc_idx` shows the slot the next load will take. Each accepted load advances it by one, and it wraps from LQ_CAP to 0.
- R3: Each load records a store tag of {1, `sq_tail`} when `sq_empty` is low, and {0, 0} when it is high. The tag of a captured violator is shown on `viol_sq_tag`.
- R4: With `commit_valid` high, all loads whose sequence number is at or below `commit_seq` leave from the head in a single cycle, and `lq_count` drops by that number.
- R5: With `squash_valid` high, all loads whose sequence number is above `squash_seq` are removed, and `alloc_idx` returns to the slot of the oldest removed load. During that cycle, commit and allocation have no effect.
- R6: `exec_valid` marks the live load at `exec_idx` as executed and stores its address. A second execute on the same slot replaces the stored address.
- R7: A check (`chk_valid`) covers the loads from `chk_lq_idx` up to the tail, not including the tail. Within that window, an executed load matches if address bits [ADDR_W-1:8] are equal. On a match, the violator registers are loaded and `chk_fault` pulses for one cycle after the check. Loads older than `chk_lq_idx` never match.
- R8: If several loads match, the violator is the one nearest `chk_lq_idx` in ring order, which matters when the window wraps past the last slot.
- R9: A load that has not executed never matches, even when its slot still holds an address from a previous occupant.
- R10: While `viol_valid` is high, checks change nothing and raise no fault. `viol_take` clears `viol_valid` on the next edge.
- R11: `free_slots` equals min(LQ_CAP − `lq_count`, SQ_CAP − `sq_used`).
- R12: After reset the queue is empty, `alloc_idx` is 0, no violator is held and `chk_fault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A load is offered for allocation |
| alloc_ready | output | 1 | The queue can accept a load |
| alloc_seq | input | SEQ_W | Sequence number of the offered load |
| alloc_idx | output | IDX_W | Slot the next load will take |
| sq_tail | input | SQ_IDX_W | Current store-queue tail index |
| sq_empty | input | 1 | The store queue holds no stores |
| sq_used | input | SQ_CNT_W | Store-queue occupancy |
| exec_valid | input | 1 | A load has executed |
| exec_idx | input | IDX_W | Slot of the executed load |
| exec_addr | input | ADDR_W | Address of the executed load |
| commit_valid | input | 1 | Commit update |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Loads above this number are removed |
| chk_valid | input | 1 | A store executes and requests a check |
| chk_lq_idx | input | IDX_W | Load-queue index the store recorded |
| chk_addr | input | ADDR_W | Store address |
| chk_fault | output | 1 | One-cycle pulse when a violator is captured |
| viol_valid | output | 1 | A violator is held |
| viol_idx | output | IDX_W | Slot of the violating load |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| viol_sq_tag | output | SQ_IDX_W+1 | Store tag of the violating load |
| viol_take | input | 1 | Consume and clear the held violator |
| lq_count | output | CNT_W | Number of live loads |
| free_slots | output | CNT_W | Free entries reported to dispatch |

## Verification
The hardest case to reach from the ports is a check window that wraps from the last slot back to slot 0, with matching loads on both sides of the wrap. The oldest match then sits at a higher index than a younger one. To build that state, the stimulus fills the ring part way and commits it empty, which leaves the head just before the end of the ring. It then allocates four loads across the boundary and executes three of them in the same 256-byte granule. A second hard case is a stale address left in a recycled slot. To reach it, a load is executed and committed, and a new, unexecuted load is allocated into the same slot.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
  // Step forward k places on a ring of n slots.
  function automatic int ring_fwd(int a, int k, int n);
    int s;
    s = a + k;
    return (s >= n) ? s - n : s;
  endfunction

  // Step back k places on a ring of n slots.
  function automatic int ring_back(int a, int k, int n);
    int s;
    s = a - k;
    return (s < 0) ? s + n : s;
  endfunction

  // Number of places from 'from' forward to 'to'.
  function automatic int ring_dist(int from, int to, int n);
    return (to >= from) ? to - from : to + n - from;
  endfunction
endpackage

// File: rtl/ldq_ring_ptrs.sv
module ldq_ring_ptrs #(
  parameter int RING  = 7,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CNT_W-1:0] pop_n,
  input  logic [CNT_W-1:0] drop_n,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  import ldq_pkg::*;

  // The parent never raises push or pop_n in a cycle where drop_n is nonzero.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head <= IDX_W'(ring_fwd(int'(head), int'(pop_n), RING));
      if (drop_n != '0)
        tail <= IDX_W'(ring_back(int'(tail), int'(drop_n), RING));
      else if (push)
        tail <= IDX_W'(ring_fwd(int'(tail), 1, RING));
      count <= CNT_W'(int'(count) + int'(push) - int'(pop_n) - int'(drop_n));
    end
  end
endmodule

// File: rtl/ldq_age_scan.sv
module ldq_age_scan #(
  parameter int RING  = 7,
  parameter int IDX_W = 3,
  parameter int TAG_W = 24
) (
  input  logic [RING-1:0]            live,
  input  logic [RING-1:0]            done,
  input  logic [RING-1:0][TAG_W-1:0] gran,
  input  logic [IDX_W-1:0]           start,
  input  logic [IDX_W-1:0]           tail,
  input  logic [TAG_W-1:0]           probe,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx
);
  import ldq_pkg::*;

  // Visit slots in age order from start; the first match is the oldest one.
  always_comb begin
    int span;
    hit     = 1'b0;
    hit_idx = '0;
    span    = ring_dist(int'(start), int'(tail), RING);
    for (int k = 0; k < RING; k++) begin
      int p;
      p = ring_fwd(int'(start), k, RING);
      if (!hit && k < span && live[p] && done[p] && gran[p] == probe) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/ldq_order_ring.sv
module ldq_order_ring #(
  parameter int LQ_CAP    = 6,
  parameter int SQ_CAP    = 4,
  parameter int SEQ_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 8,
  localparam int RING     = LQ_CAP + 1,
  localparam int IDX_W    = $clog2(RING),
  localparam int CNT_W    = $clog2(LQ_CAP + 1),
  localparam int SQ_IDX_W = $clog2(SQ_CAP + 1),
  localparam int SQ_CNT_W = $clog2(SQ_CAP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_valid,
  output logic                alloc_ready,
  input  logic [SEQ_W-1:0]    alloc_seq,
  output logic [IDX_W-1:0]    alloc_idx,
  input  logic [SQ_IDX_W-1:0] sq_tail,
  input  logic                sq_empty,
  input  logic [SQ_CNT_W-1:0] sq_used,
  input  logic                exec_valid,
  input  logic [IDX_W-1:0]    exec_idx,
  input  logic [ADDR_W-1:0]   exec_addr,
  input  logic                commit_valid,
  input  logic [SEQ_W-1:0]    commit_seq,
  input  logic                squash_valid,
  input  logic [SEQ_W-1:0]    squash_seq,
  input  logic                chk_valid,
  input  logic [IDX_W-1:0]    chk_lq_idx,
  input  logic [ADDR_W-1:0]   chk_addr,
  output logic                chk_fault,
  output logic                viol_valid,
  output logic [IDX_W-1:0]    viol_idx,
  output logic [SEQ_W-1:0]    viol_seq,
  output logic [SQ_IDX_W:0]   viol_sq_tag,
  input  logic                viol_take,
  output logic [CNT_W-1:0]    lq_count,
  output logic [CNT_W-1:0]    free_slots
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic [RING-1:0]             e_live, e_done, kill_old, kill_young;
  logic [RING-1:0][SEQ_W-1:0]  e_seq;
  logic [RING-1:0][TAG_W-1:0]  e_gran;
  logic [RING-1:0][SQ_IDX_W:0] e_sqtag;
  logic [IDX_W-1:0]            head, tail;
  logic [CNT_W-1:0]            pop_n, drop_n;
  logic                        alloc_fire, scan_hit;
  logic [IDX_W-1:0]            scan_idx;
  logic [SQ_IDX_W:0]           new_tag;

  assign alloc_ready = (lq_count < CNT_W'(LQ_CAP)) && !squash_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail;
  assign new_tag     = sq_empty ? '0 : {1'b1, sq_tail};

  // Loads are stored in program order, so the committed set is a prefix
  // starting at the head and the squashed set is a suffix ending at the tail.
  always_comb begin
    for (int i = 0; i < RING; i++) begin
      kill_young[i] = squash_valid && e_live[i] && (e_seq[i] > squash_seq);
      kill_old[i]   = !squash_valid && commit_valid && e_live[i] &&
                      (e_seq[i] <= commit_seq);
    end
    pop_n  = CNT_W'($countones(kill_old));
    drop_n = CNT_W'($countones(kill_young));
  end

  ldq_ring_ptrs #(.RING(RING), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(alloc_fire), .pop_n(pop_n),
    .drop_n(drop_n), .head(head), .tail(tail), .count(lq_count)
  );

  for (genvar g = 0; g < RING; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_live[g]  <= 1'b0;
        e_done[g]  <= 1'b0;
        e_seq[g]   <= '0;
        e_gran[g]  <= '0;
        e_sqtag[g] <= '0;
      end else if (alloc_fire && tail == IDX_W'(g)) begin
        e_live[g]  <= 1'b1;
        e_done[g]  <= 1'b0;
        e_seq[g]   <= alloc_seq;
        e_sqtag[g] <= new_tag;
      end else if (kill_young[g] || kill_old[g]) begin
        e_live[g] <= 1'b0;
        e_done[g] <= 1'b0;
      end else if (exec_valid && exec_idx == IDX_W'(g) && e_live[g]) begin
        e_done[g] <= 1'b1;
        e_gran[g] <= exec_addr[ADDR_W-1:GRAN_BITS];
      end
    end
  end

  ldq_age_scan #(.RING(RING), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_scan (
    .live(e_live), .done(e_done), .gran(e_gran), .start(chk_lq_idx),
    .tail(tail), .probe(chk_addr[ADDR_W-1:GRAN_BITS]),
    .hit(scan_hit), .hit_idx(scan_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_fault   <= 1'b0;
      viol_valid  <= 1'b0;
      viol_idx    <= '0;
      viol_seq    <= '0;
      viol_sq_tag <= '0;
    end else begin
      chk_fault <= 1'b0;
      if (viol_valid) begin
        if (viol_take) viol_valid <= 1'b0;
      end else if (chk_valid && scan_hit) begin
        chk_fault   <= 1'b1;
        viol_valid  <= 1'b1;
        viol_idx    <= scan_idx;
        viol_seq    <= e_seq[scan_idx];
        viol_sq_tag <= e_sqtag[scan_idx];
      end
    end
  end

  always_comb begin
    logic [CNT_W-1:0] lq_free, sq_free;
    lq_free    = CNT_W'(LQ_CAP) - lq_count;
    sq_free    = CNT_W'(SQ_CAP - int'(sq_used));
    free_slots = (lq_free < sq_free) ? lq_free : sq_free;
  end
endmodule

// File: rtl/ldq_order_ring_chk.sv
module ldq_order_ring_chk #(
  parameter int LQ_CAP = 6,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 3,
  parameter int SEQ_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             commit_valid,
  input logic             squash_valid,
  input logic             chk_valid,
  input logic             chk_fault,
  input logic             viol_valid,
  input logic [SEQ_W-1:0] viol_seq,
  input logic             viol_take,
  input logic [CNT_W-1:0] lq_count
);
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    lq_count <= CNT_W'(LQ_CAP));
  a_r1_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_count == CNT_W'(LQ_CAP)) |-> !alloc_ready);
  a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !commit_valid) |=>
      (lq_count == $past(lq_count) + 1'b1));
  a_r5_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (lq_count <= $past(lq_count)));
  a_r7_fault_from_check: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |-> ($past(chk_valid) && viol_valid && !$past(viol_valid)));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !viol_take) |=> (viol_valid && $stable(viol_seq)));
  a_r10_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_take) |=> !viol_valid);
endmodule

bind ldq_order_ring ldq_order_ring_chk #(
  .LQ_CAP(LQ_CAP), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready), .commit_valid(commit_valid),
  .squash_valid(squash_valid), .chk_valid(chk_valid), .chk_fault(chk_fault),
  .viol_valid(viol_valid), .viol_seq(viol_seq), .viol_take(viol_take),
  .lq_count(lq_count)
);

// File: tb/test_ldq_order_ring.sv
`timescale 1ns/1ps
module test_ldq_order_ring;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 0, sq_empty = 1, exec_valid = 0;
  logic        commit_valid = 0, squash_valid = 0, chk_valid = 0, viol_take = 0;
  logic [15:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [2:0]  sq_tail = 0, sq_used = 0, exec_idx = 0, chk_lq_idx = 0;
  logic [31:0] exec_addr = 0, chk_addr = 0;
  logic        alloc_ready, chk_fault, viol_valid;
  logic [2:0]  alloc_idx, viol_idx, lq_count, free_slots;
  logic [15:0] viol_seq;
  logic [3:0]  viol_sq_tag;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ldq_order_ring i_ldq_order_ring (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_seq(alloc_seq), .alloc_idx(alloc_idx), .sq_tail(sq_tail),
    .sq_empty(sq_empty), .sq_used(sq_used), .exec_valid(exec_valid),
    .exec_idx(exec_idx), .exec_addr(exec_addr), .commit_valid(commit_valid),
    .commit_seq(commit_seq), .squash_valid(squash_valid), .squash_seq(squash_seq),
    .chk_valid(chk_valid), .chk_lq_idx(chk_lq_idx), .chk_addr(chk_addr),
    .chk_fault(chk_fault), .viol_valid(viol_valid), .viol_idx(viol_idx),
    .viol_seq(viol_seq), .viol_sq_tag(viol_sq_tag), .viol_take(viol_take),
    .lq_count(lq_count), .free_slots(free_slots)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_alloc(input logic [15:0] s, input logic emp, input logic [2:0] st);
    alloc_valid = 1; alloc_seq = s; sq_empty = emp; sq_tail = st;
    cyc(); alloc_valid = 0;
  endtask
  task automatic do_exec(input logic [2:0] i, input logic [31:0] a);
    exec_valid = 1; exec_idx = i; exec_addr = a; cyc(); exec_valid = 0;
  endtask
  task automatic do_commit(input logic [15:0] s);
    commit_valid = 1; commit_seq = s; cyc(); commit_valid = 0;
  endtask
  task automatic do_chk(input logic [2:0] i, input logic [31:0] a);
    chk_valid = 1; chk_lq_idx = i; chk_addr = a; cyc(); chk_valid = 0;
  endtask
  task automatic do_take();
    viol_take = 1; cyc(); viol_take = 0;
  endtask

  task automatic t_reset();
    check("R12", "count", lq_count, 0);
    check("R12", "alloc_idx", alloc_idx, 0);
    check("R12", "viol_valid", viol_valid, 0);
    check("R12", "chk_fault", chk_fault, 0);
    check("R1", "ready when empty", alloc_ready, 1);
    check("R11", "free sq empty", free_slots, 4);
    sq_used = 3; #1;
    check("R11", "free limited by stores", free_slots, 1);
    sq_used = 0; #1;
  endtask

  task automatic t_fill_wrap();
    for (int k = 0; k < 6; k++) begin
      check("R2", "alloc_idx in order", alloc_idx, k);
      do_alloc(16'(k + 1), 1, 0);
    end
    check("R1", "count full", lq_count, 6);
    check("R1", "ready low when full", alloc_ready, 0);
    check("R11", "free when full", free_slots, 0);
    do_alloc(16'd99, 1, 0);
    check("R1", "offer to full queue ignored", lq_count, 6);
    do_commit(16'd2);
    check("R4", "commit two", lq_count, 4);
    check("R2", "alloc_idx last slot", alloc_idx, 6);
    do_alloc(16'd7, 1, 0);
    do_exec(3'd6, 32'h7700);
    check("R2", "alloc_idx wraps", alloc_idx, 0);
    do_alloc(16'd8, 1, 0);
    check("R2", "count after wrap", lq_count, 6);
    do_commit(16'd100);
    check("R4", "commit all", lq_count, 0);
    check("R4", "alloc_idx after drain", alloc_idx, 1);
  endtask

  task automatic t_squash();
    for (int k = 0; k < 4; k++) do_alloc(16'(10 + k), 1, 0);
    squash_valid = 1; squash_seq = 16'd11;
    alloc_valid = 1; alloc_seq = 16'd14;
    commit_valid = 1; commit_seq = 16'd20;
    #1 check("R1", "ready low during squash", alloc_ready, 0);
    cyc();
    squash_valid = 0; alloc_valid = 0; commit_valid = 0;
    check("R5", "count after squash", lq_count, 2);
    check("R5", "tail pulled back", alloc_idx, 3);
    do_commit(16'd100);
    check("R4", "drain after squash", lq_count, 0);
  endtask

  task automatic t_violation();
    do_alloc(16'd20, 1, 0);   // slot 3, store queue empty
    do_alloc(16'd21, 0, 2);   // slot 4
    do_alloc(16'd22, 0, 2);   // slot 5
    do_alloc(16'd23, 0, 2);   // slot 6, never executed, stale 0x77 granule
    do_exec(3'd3, 32'h1234);
    do_exec(3'd5, 32'h2250);
    do_exec(3'd4, 32'h1300);
    do_chk(3'd4, 32'h12FF);
    check("R7", "older load outside window", chk_fault, 0);
    do_chk(3'd4, 32'h7711);
    check("R9", "unexecuted load no match", viol_valid, 0);
    do_chk(3'd4, 32'h22AB);
    check("R7", "fault pulse", chk_fault, 1);
    check("R7", "viol idx", viol_idx, 5);
    check("R7", "viol seq", viol_seq, 22);
    check("R3", "tag with stores", viol_sq_tag, 4'hA);
    cyc();
    check("R7", "fault one cycle", chk_fault, 0);
  endtask

  task automatic t_sticky();
    do_chk(3'd4, 32'h1300);
    check("R10", "no fault while held", chk_fault, 0);
    check("R10", "violator unchanged", viol_seq, 22);
    do_take();
    check("R10", "take clears", viol_valid, 0);
    do_chk(3'd3, 32'h1200);
    check("R10", "capture after take", viol_seq, 20);
    check("R3", "empty marker tag", viol_sq_tag, 0);
    do_take();
  endtask

  task automatic t_oldest();
    do_exec(3'd6, 32'h22CC);
    do_chk(3'd4, 32'h2200);
    check("R8", "oldest of two", viol_idx, 5);
    do_take();
    do_commit(16'd100);
    for (int k = 0; k < 5; k++) do_alloc(16'(40 + k), 1, 0);
    do_commit(16'd44);
    check("R2", "head near end", alloc_idx, 5);
    for (int k = 0; k < 4; k++) do_alloc(16'(50 + k), 1, 0);
    do_exec(3'd1, 32'h4410);
    do_exec(3'd0, 32'h4420);
    do_exec(3'd6, 32'h4430);
    do_chk(3'd6, 32'h4400);
    check("R8", "wrap oldest idx", viol_idx, 6);
    check("R8", "wrap oldest seq", viol_seq, 51);
    do_take();
    do_chk(3'd0, 32'h4400);
    check("R8", "window from slot 0", viol_idx, 0);
    do_take();
  endtask

  task automatic t_reexec();
    do_exec(3'd1, 32'h9900);
    do_chk(3'd1, 32'h4400);
    check("R6", "old address replaced", viol_valid, 0);
    do_chk(3'd1, 32'h99AA);
    check("R6", "new address matches", viol_seq, 53);
    do_take();
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_fill_wrap();
    t_squash();
    t_violation();
    t_sticky();
    t_oldest();
    t_reexec();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule